// File: doc/BRIEF.md
# I2C Controller Register Front End

This block is the software-visible register file of an I2C controller. A host reaches it over a simple word-addressed bus that has separate read and write strobes. The block turns accesses on that bus into the control bits, timing values and transmit data used by a separate protocol engine. It also returns the engine's bus-state code and its interrupt request to software. The bit-level I2C sequencing and the pad drivers belong to the engine and are not part of this block.

Software never writes the control byte directly. It uses two aliases: writing ones through one alias sets the matching bits, and writing ones through the other alias clears them. The serial interrupt flag lives in bit 3 of the control byte. Only the engine can set it, and only software can clear it. While the flag is up, the status code that software reads is held, so an interrupt service routine sees the state that raised the interrupt. The interrupt output is the flag gated by an enable bit.

Top module: `i2c_reg_front`

## Requirements
- R1: A write to the set alias (byte offset 0x00) sets each control bit whose position holds a one in the written value, except bit 3, and leaves all other bits unchanged. A read of offset 0x00 returns the control byte.
- R2: A write to the clear alias (offset 0x18) clears each control bit whose position holds a one in the written value and leaves the other bits unchanged. A read of offset 0x18 returns zero.
- R3: Control bit 3 is the serial interrupt flag. A one-cycle pulse on `engIntPulse` sets it at the next clock edge. Only the clear alias clears it. If a clear of bit 3 and a pulse occur in the same cycle, the flag ends up set.
- R4: The status register at offset 0x04 reads the 5-bit engine code in bits 7:3, and bits 2:0 always read as zero. The code is captured on a pulse that finds the flag clear, or that coincides with a clear of bit 3. Otherwise the code holds its value, whatever `engCode` does.
- R5: After reset, the register values are: status 0xF8; control, data and slave address 0x00; SCL high and SCL low 0x0004.
- R6: `irq` is high exactly when the interrupt flag (bit 3) and the interface enable (control bit 6) are both set.
- R7: The data register at offset 0x08 reads back the last byte written, drives `txData`, and raises `txLoad` for the one cycle that follows the write edge.
- R8: The slave address register at offset 0x0C reads back as written. Its bits 7:1 drive `slvAddr`, and its bit 0 drives `gcEnable`.
- R9: The SCL high register (offset 0x10) and the SCL low register (offset 0x14) are 16 bits wide. They read back as written and drive `sclHigh` and `sclLow`.
- R10: Writes to the status offset and to the unmapped offset 0x1C change no register. A read of an unmapped offset returns zero.
- R11: Read data is registered. `busRdata` changes only at the clock edge where `busRd` is high, and then shows the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address; bits 1:0 ignored |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Registered read data |
| engCode | input | 5 | Bus-state code from the engine |
| engIntPulse | input | 1 | One-cycle interrupt request from the engine |
| ctrlBits | output | 8 | Control byte |
| txData | output | 8 | Data register contents |
| txLoad | output | 1 | One-cycle strobe after a data write |
| slvAddr | output | 7 | Own slave address |
| gcEnable | output | 1 | General call response enable |
| sclHigh | output | 16 | SCL high period |
| sclLow | output | 16 | SCL low period |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 5-bit address, a 16-bit bus and 16-bit SCL period registers. With a 5-bit address, all eight word slots can be reached, including the one unmapped slot at 0x1C. The 16-bit bus lets full-width values reach the period registers, while the upper byte written to the 8-bit registers can be seen to drop. With these widths, the flag and code interplay can be driven cycle by cycle: a pulse while the flag is already set, and a clear that meets a pulse in the same cycle.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int WORD_CTRL = 0;
  localparam int WORD_STAT = 1;
  localparam int WORD_DATA = 2;
  localparam int WORD_ADR  = 3;
  localparam int WORD_SCLH = 4;
  localparam int WORD_SCLL = 5;
  localparam int WORD_CLR  = 6;

  typedef struct packed {
    logic wrSet;
    logic wrClr;
    logic wrData;
    logic wrAdr;
    logic wrSclH;
    logic wrSclL;
  } wrStrobes_t;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_ADR, SEL_SCLH, SEL_SCLL
  } rdSel_t;

  typedef struct packed {
    wrStrobes_t wr;
    logic       rdEn;
    rdSel_t     rdSel;
  } busCmd_t;

endpackage

// File: rtl/i2c_reg_decode.sv
module i2c_reg_decode
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output busCmd_t           cmd
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    cmd = '0;
    cmd.rdEn  = busRd;
    cmd.rdSel = SEL_ZERO;
    case (int'(wordIdx))
      WORD_CTRL: begin cmd.wr.wrSet  = busWr; cmd.rdSel = SEL_CTRL; end
      WORD_STAT: begin cmd.rdSel = SEL_STAT; end
      WORD_DATA: begin cmd.wr.wrData = busWr; cmd.rdSel = SEL_DATA; end
      WORD_ADR:  begin cmd.wr.wrAdr  = busWr; cmd.rdSel = SEL_ADR;  end
      WORD_SCLH: begin cmd.wr.wrSclH = busWr; cmd.rdSel = SEL_SCLH; end
      WORD_SCLL: begin cmd.wr.wrSclL = busWr; cmd.rdSel = SEL_SCLL; end
      WORD_CLR:  begin cmd.wr.wrClr  = busWr; end
      default:   begin end
    endcase
  end

  // R10: a write never raises more than one register strobe
  always_comb begin
    if (busWr) a_r10_single_target: assert ($onehot0(cmd.wr));
  end

endmodule

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_reg_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int SCL_W  = 16,
  parameter int CODE_W = 5,
  parameter int REG_W  = 8,
  parameter int SI_BIT = 3,
  parameter int EN_BIT = 6,
  parameter logic [SCL_W-1:0] SCL_RST = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  busCmd_t          cmd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  input  logic [CODE_W-1:0] engCode,
  input  logic             engIntPulse,
  output logic [REG_W-1:0] ctrlBits,
  output logic [REG_W-1:0] txData,
  output logic             txLoad,
  output logic [REG_W-2:0] slvAddr,
  output logic             gcEnable,
  output logic [SCL_W-1:0] sclHigh,
  output logic [SCL_W-1:0] sclLow,
  output logic             irq
);

  localparam int LOW_W = REG_W - CODE_W;
  localparam logic [REG_W-1:0] SI_MASK = REG_W'(1) << SI_BIT;

  logic [REG_W-1:0]  ctrlReg, ctrlNext;
  logic [CODE_W-1:0] statCode;
  logic [REG_W-1:0]  dataReg, adrReg;
  logic [SCL_W-1:0]  sclHReg, sclLReg;
  logic [REG_W-1:0]  wByte;
  logic              clrSi, takeCode;
  logic [BUS_W-1:0]  rdMux;

  assign wByte    = busWdata[REG_W-1:0];
  assign clrSi    = cmd.wr.wrClr && wByte[SI_BIT];
  assign takeCode = engIntPulse && (!ctrlReg[SI_BIT] || clrSi);

  always_comb begin
    ctrlNext = ctrlReg;
    if (cmd.wr.wrSet) ctrlNext = ctrlNext | (wByte & ~SI_MASK);
    if (cmd.wr.wrClr) ctrlNext = ctrlNext & ~wByte;
    if (engIntPulse)  ctrlNext[SI_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      statCode <= '1;
      dataReg  <= '0;
      adrReg   <= '0;
      sclHReg  <= SCL_RST;
      sclLReg  <= SCL_RST;
      txLoad   <= 1'b0;
    end else begin
      ctrlReg <= ctrlNext;
      if (takeCode)      statCode <= engCode;
      if (cmd.wr.wrData) dataReg  <= wByte;
      if (cmd.wr.wrAdr)  adrReg   <= wByte;
      if (cmd.wr.wrSclH) sclHReg  <= busWdata[SCL_W-1:0];
      if (cmd.wr.wrSclL) sclLReg  <= busWdata[SCL_W-1:0];
      txLoad <= cmd.wr.wrData;
    end
  end

  always_comb begin
    case (cmd.rdSel)
      SEL_CTRL: rdMux = BUS_W'(ctrlReg);
      SEL_STAT: rdMux = BUS_W'({statCode, {LOW_W{1'b0}}});
      SEL_DATA: rdMux = BUS_W'(dataReg);
      SEL_ADR:  rdMux = BUS_W'(adrReg);
      SEL_SCLH: rdMux = BUS_W'(sclHReg);
      SEL_SCLL: rdMux = BUS_W'(sclLReg);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (cmd.rdEn)  busRdata <= rdMux;
  end

  assign ctrlBits = ctrlReg;
  assign txData   = dataReg;
  assign slvAddr  = adrReg[REG_W-1:1];
  assign gcEnable = adrReg[0];
  assign sclHigh  = sclHReg;
  assign sclLow   = sclLReg;
  assign irq      = ctrlReg[SI_BIT] && ctrlReg[EN_BIT];

  // R1: a set-alias write never drops a bit that was already set
  a_r1_set_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wr.wrSet && !engIntPulse) |=> ((ctrlReg & $past(ctrlReg)) == $past(ctrlReg)));

  // R2: clearing bit 3 without a competing pulse drops the flag
  a_r2_clear_flag: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wr.wrClr && busWdata[SI_BIT] && !engIntPulse) |=> !ctrlBits[SI_BIT]);

  // R3: an engine pulse always leaves the flag set
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    engIntPulse |=> ctrlBits[SI_BIT]);

  // R4: while the flag stays up, the captured code does not move
  a_r4_code_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits[SI_BIT] && !(cmd.wr.wrClr && busWdata[SI_BIT])) |=> $stable(statCode));

  // R7: a data write is followed by the load strobe
  a_r7_tx_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wr.wrData |=> txLoad);

  // R11: read data moves only on a read cycle
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front
  import i2c_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16,
  parameter int SCL_W  = 16,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [CODE_W-1:0] engCode,
  input  logic              engIntPulse,
  output logic [7:0]        ctrlBits,
  output logic [7:0]        txData,
  output logic              txLoad,
  output logic [6:0]        slvAddr,
  output logic              gcEnable,
  output logic [SCL_W-1:0]  sclHigh,
  output logic [SCL_W-1:0]  sclLow,
  output logic              irq
);

  busCmd_t cmd;

  i2c_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .cmd    (cmd)
  );

  i2c_reg_datapath #(
    .BUS_W (BUS_W),
    .SCL_W (SCL_W),
    .CODE_W(CODE_W),
    .REG_W (8)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .engCode    (engCode),
    .engIntPulse(engIntPulse),
    .ctrlBits   (ctrlBits),
    .txData     (txData),
    .txLoad     (txLoad),
    .slvAddr    (slvAddr),
    .gcEnable   (gcEnable),
    .sclHigh    (sclHigh),
    .sclLow     (sclLow),
    .irq        (irq)
  );

endmodule

// File: tb/sim_i2c_reg_front.sv
module sim_i2c_reg_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [4:0]  engCode = '0;
  logic        engIntPulse = 1'b0;
  logic [7:0]  ctrlBits, txData;
  logic        txLoad, gcEnable, irq;
  logic [6:0]  slvAddr;
  logic [15:0] sclHigh, sclLow;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  i2c_reg_front u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .engCode(engCode),
    .engIntPulse(engIntPulse), .ctrlBits(ctrlBits), .txData(txData),
    .txLoad(txLoad), .slvAddr(slvAddr), .gcEnable(gcEnable),
    .sclHigh(sclHigh), .sclLow(sclLow), .irq(irq)
  );

  typedef struct packed {
    logic        isWr;
    logic [4:0]  addr;
    logic [15:0] val;   // write data, or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 5'h04, 16'h00F8, 8'd5},  // R5 status reset
    '{1'b0, 5'h00, 16'h0000, 8'd5},  // R5 control reset
    '{1'b0, 5'h08, 16'h0000, 8'd5},  // R5 data reset
    '{1'b0, 5'h0C, 16'h0000, 8'd5},  // R5 address reset
    '{1'b0, 5'h10, 16'h0004, 8'd5},  // R5 SCL high reset
    '{1'b0, 5'h14, 16'h0004, 8'd5},  // R5 SCL low reset
    '{1'b1, 5'h00, 16'h0044, 8'd1},  // R1 set bits 6 and 2
    '{1'b0, 5'h00, 16'h0044, 8'd1},
    '{1'b1, 5'h00, 16'h0009, 8'd1},  // R1 bit 3 ignored, bit 0 set
    '{1'b0, 5'h00, 16'h0045, 8'd1},
    '{1'b1, 5'h18, 16'h0005, 8'd2},  // R2 clear bits 2 and 0
    '{1'b0, 5'h00, 16'h0040, 8'd2},
    '{1'b0, 5'h18, 16'h0000, 8'd2},  // R2 clear alias reads zero
    '{1'b1, 5'h0C, 16'hFF35, 8'd8},  // R8 upper byte dropped
    '{1'b0, 5'h0C, 16'h0035, 8'd8},
    '{1'b1, 5'h10, 16'h1234, 8'd9},  // R9
    '{1'b1, 5'h14, 16'hBEEF, 8'd9},
    '{1'b0, 5'h10, 16'h1234, 8'd9},
    '{1'b0, 5'h14, 16'hBEEF, 8'd9},
    '{1'b1, 5'h04, 16'h0000, 8'd10}, // R10 status write ignored
    '{1'b0, 5'h04, 16'h00F8, 8'd10},
    '{1'b1, 5'h1C, 16'hFFFF, 8'd10}  // R10 unmapped write
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input logic [4:0] code, input logic withClr);
    @(negedge clk);
    engCode = code; engIntPulse = 1'b1;
    if (withClr) begin busAddr = 5'h18; busWdata = 16'h0008; busWr = 1'b1; end
    @(negedge clk);
    engIntPulse = 1'b0; busWr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R5 reset outputs
    chk("R5 sclHigh", sclHigh, 16'h0004);
    chk("R6 irq at reset", {15'b0, irq}, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) busWrite(VEC[i].addr, VEC[i].val);
      else begin
        busRead(VEC[i].addr, rd);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].val);
      end
    end

    // R10 unmapped read zero, nothing disturbed
    busRead(5'h1C, rd); chk("R10 unmapped read", rd, 16'h0000);
    busRead(5'h00, rd); chk("R10 control intact", rd, 16'h0040);
    chk("R8 slvAddr", {9'b0, slvAddr}, 16'h001A);
    chk("R8 gcEnable", {15'b0, gcEnable}, 16'h0001);
    chk("R9 sclLow out", sclLow, 16'hBEEF);

    // R7 data write and load strobe
    busWrite(5'h08, 16'h77A5);
    chk("R7 txLoad high", {15'b0, txLoad}, 16'h0001);
    chk("R7 txData", {8'b0, txData}, 16'h00A5);
    @(negedge clk);
    chk("R7 txLoad one cycle", {15'b0, txLoad}, 16'h0000);
    busRead(5'h08, rd); chk("R7 readback", rd, 16'h00A5);

    // R11 read data holds without a read strobe
    @(negedge clk); busAddr = 5'h10;
    @(negedge clk); chk("R11 hold", busRdata, 16'h00A5);

    // R3 R4 R6 flag and frozen code
    pulse(5'h0A, 1'b0);
    chk("R3 flag set", {15'b0, ctrlBits[3]}, 16'h0001);
    chk("R6 irq with enable", {15'b0, irq}, 16'h0001);
    busRead(5'h04, rd); chk("R4 captured code", rd, 16'h0050);
    engCode = 5'h11;
    pulse(5'h13, 1'b0);
    busRead(5'h04, rd); chk("R4 frozen while flag set", rd, 16'h0050);
    busWrite(5'h00, 16'h0000);
    busWrite(5'h18, 16'h0008);
    chk("R2 flag cleared", {15'b0, ctrlBits[3]}, 16'h0000);
    chk("R6 irq low after clear", {15'b0, irq}, 16'h0000);
    busRead(5'h04, rd); chk("R4 hold after clear", rd, 16'h0050);
    pulse(5'h11, 1'b0);
    busRead(5'h04, rd); chk("R4 recapture", rd, 16'h0088);
    pulse(5'h02, 1'b1);
    chk("R3 set wins over clear", {15'b0, ctrlBits[3]}, 16'h0001);
    busRead(5'h04, rd); chk("R4 capture with clear", rd, 16'h0010);
    busWrite(5'h18, 16'h0040);
    chk("R6 irq gated by enable", {15'b0, irq}, 16'h0000);
    chk("R3 flag kept", {15'b0, ctrlBits[3]}, 16'h0001);
    busWrite(5'h00, 16'h0040);
    chk("R6 irq re-enabled", {15'b0, irq}, 16'h0001);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule